// File: doc/BRIEF.md
# Byte-Wide Stack Engine

This block keeps a 16-bit stack pointer in two byte registers and moves single bytes and 16-bit return addresses between a requester and a byte-wide, single-port data memory. A requester raises a command with an opcode and, for pushes, the data. The engine runs the one or two memory accesses the command needs, moves the pointer, and pulses a completion strobe. For pops, the fetched value stays on the result output until the next pop finishes.

The pointer grows downward. A push stores at the current pointer and then decrements it. A pop increments the pointer first and then loads from the new location. A return address is stored with its upper byte at the higher address. Software can read or overwrite either pointer byte through two data-space addresses. These writes are accepted only while no command is in flight.

Top module: `stk_engine`

## Requirements
- R1: While reset is high and after it releases, the pointer is 0x0000, busy and done are low, and the pop result is zero.
- R2: A pointer write to address 0x5D loads the low pointer byte and a write to 0x5E loads the high byte. ptr_rdata shows the low byte for 0x5D, the high byte for 0x5E, and zero for every other address. A write to any other address changes nothing.
- R3: A byte push (opcode 2'b00) stores cmd_wdata[7:0] at the pointer P and leaves the pointer at P-1.
- R4: A byte pop (opcode 2'b01) loads the byte at P+1, leaves the pointer at P+1, and returns {8'h00, byte} on pop_data.
- R5: An address push (opcode 2'b10) stores cmd_wdata[15:8] at P and then cmd_wdata[7:0] at P-1, on consecutive cycles, and leaves the pointer at P-2.
- R6: An address pop (opcode 2'b11) loads the low byte from P+1 and then the high byte from P+2, leaves the pointer at P+2, and returns high×256+low.
- R7: All pointer and memory address arithmetic wraps modulo 65536.
- R8: A command is accepted on a clock edge where busy is low and cmd_valid is high. Its first memory access is in the next cycle. Byte commands use one memory cycle and address commands use two. done is high for exactly one cycle: the third cycle after acceptance for byte commands and the fourth for address commands. busy is low in that cycle.
- R9: While busy is high, cmd_valid and pointer writes are ignored.
- R10: pop_data changes only on the edge that ends a pop, and holds otherwise, including across pushes.
- R11: Memory reads are synchronous. mem_rdata is expected one cycle after a read access with mem_en high and mem_we low. mem_we is never high without mem_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 00 push byte, 01 pop byte, 10 push address, 11 pop address |
| cmd_wdata | input | 16 | Push data (byte push uses bits 7:0) |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Result of the last completed pop |
| sp_out | output | 16 | Current stack pointer |
| ptr_addr | input | 8 | Data-space address for pointer access |
| ptr_we | input | 1 | Pointer byte write enable |
| ptr_wdata | input | 8 | Pointer byte write data |
| ptr_rdata | output | 8 | Pointer byte read data (combinational) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the read |

## Verification
Counting from the accepting edge, the first memory access is due one cycle later. The second access of an address command is due in the cycle after the first. The pointer update, the new pop result and the done pulse all appear together, three cycles after acceptance for byte commands and four for address commands. The bench's reference model counts down those same cycles behaviourally. On every falling edge it compares busy, done, the pointer, the result, the pointer readback and each memory access against its expectation, so an early or late result is caught in the exact cycle it goes wrong. Directed checks sample done and pop_data in the cycle of the pulse, and confirm that commands and pointer writes issued mid-operation leave no trace.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STK_AW = 16;
    localparam int STK_DW = 8;

    typedef enum logic [1:0] {
        OP_PUSH_B = 2'b00,
        OP_POP_B  = 2'b01,
        OP_PUSH_W = 2'b10,
        OP_POP_W  = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } stk_state_e;

    function automatic logic op_is_pop(input stk_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_word(input stk_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/stk_ptr_regs.sv
module stk_ptr_regs #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int RA_W    = 8,
    parameter int LO_ADDR = 'h5D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RA_W-1:0] acc_addr,
    input  logic            acc_we,
    input  logic [DW-1:0]   acc_wdata,
    input  logic            acc_allow,
    input  logic            upd_en,
    input  logic [AW-1:0]   upd_val,
    output logic [AW-1:0]   sp,
    output logic [DW-1:0]   acc_rdata
);
    localparam int NH = AW / DW;

    for (genvar h = 0; h < NH; h++) begin : g_half
        logic          hit;
        logic [DW-1:0] q;

        assign hit = acc_we && acc_allow && (acc_addr == RA_W'(LO_ADDR + h));

        always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (upd_en) q <= upd_val[h*DW +: DW];
            else if (hit)    q <= acc_wdata;
        end

        assign sp[h*DW +: DW] = q;
    end

    always_comb begin
        acc_rdata = '0;
        for (int h = 0; h < NH; h++) begin
            if (acc_addr == RA_W'(LO_ADDR + h)) acc_rdata = sp[h*DW +: DW];
        end
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [2*DW-1:0] cmd_wdata,
    input  logic [AW-1:0]   sp,
    output logic            upd_en,
    output logic [AW-1:0]   upd_val,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] pop_data,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    stk_state_e      state_q, state_d;
    stk_op_e         op_q;
    logic [2*DW-1:0] wd_q;
    logic [DW-1:0]   lo_q;
    logic [2*DW-1:0] res_q;
    logic            done_q;
    logic            pop_w, word_w, accept;
    logic [AW-1:0]   step;

    assign pop_w  = op_is_pop(op_q);
    assign word_w = op_is_word(op_q);
    assign accept = (state_q == ST_IDLE) && cmd_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FIRST;
            ST_FIRST:  state_d = word_w ? ST_SECOND : ST_DONE;
            ST_SECOND: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_en = (state_q == ST_FIRST) || (state_q == ST_SECOND);
        mem_we = mem_en && !pop_w;
        if (pop_w) mem_addr = sp + ((state_q == ST_SECOND) ? TWO : ONE);
        else       mem_addr = (state_q == ST_SECOND) ? (sp - ONE) : sp;
        mem_wdata = ((state_q == ST_FIRST) && word_w) ? wd_q[2*DW-1:DW] : wd_q[DW-1:0];
        step    = word_w ? TWO : ONE;
        upd_val = pop_w ? (sp + step) : (sp - step);
        upd_en  = (state_q == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PUSH_B;
            wd_q    <= '0;
            lo_q    <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_DONE);
            if (accept) begin
                op_q <= stk_op_e'(cmd_op);
                wd_q <= cmd_wdata;
            end
            if (state_q == ST_SECOND && pop_w) lo_q <= mem_rdata;
            if (state_q == ST_DONE && pop_w) begin
                res_q <= word_w ? {mem_rdata, lo_q} : {{DW{1'b0}}, mem_rdata};
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign pop_data = res_q;

endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter int AW      = STK_AW,
    parameter int DW      = STK_DW,
    parameter int RA_W    = 8,
    parameter int LO_ADDR = 'h5D
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [2*DW-1:0] cmd_wdata,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] pop_data,
    output logic [AW-1:0]   sp_out,
    input  logic [RA_W-1:0] ptr_addr,
    input  logic            ptr_we,
    input  logic [DW-1:0]   ptr_wdata,
    output logic [DW-1:0]   ptr_rdata,
    output logic            mem_en,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    logic          upd_en;
    logic [AW-1:0] upd_val;
    logic [AW-1:0] sp;

    stk_ptr_regs #(.AW(AW), .DW(DW), .RA_W(RA_W), .LO_ADDR(LO_ADDR)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .acc_addr  (ptr_addr),
        .acc_we    (ptr_we),
        .acc_wdata (ptr_wdata),
        .acc_allow (!busy),
        .upd_en    (upd_en),
        .upd_val   (upd_val),
        .sp        (sp),
        .acc_rdata (ptr_rdata)
    );

    stk_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .sp        (sp),
        .upd_en    (upd_en),
        .upd_val   (upd_val),
        .busy      (busy),
        .done      (done),
        .pop_data  (pop_data),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    assign sp_out = sp;

endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic [2*DW-1:0] pop_data,
    input logic [AW-1:0]   sp_out,
    input logic            ptr_we,
    input logic            mem_en,
    input logic            mem_we
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_mem_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> busy);

    a_r9_sp_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ptr_we) |=> $stable(sp_out));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(pop_data));

    a_r11_we_needs_en: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

endmodule

bind stk_engine stk_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .pop_data (pop_data),
    .sp_out   (sp_out),
    .ptr_we   (ptr_we),
    .mem_en   (mem_en),
    .mem_we   (mem_we)
);

// File: tb/stk_engine_tb.sv
`timescale 1ns/1ps
module stk_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done;
    logic [15:0] pop_data, sp_out;
    logic [7:0]  ptr_addr = '0;
    logic        ptr_we = 1'b0;
    logic [7:0]  ptr_wdata = '0;
    logic [7:0]  ptr_rdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int unsigned checks = 0;
    int unsigned failures = 0;
    int unsigned cyc = 0;

    always #2 clk = ~clk;

    stk_engine dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .pop_data(pop_data),
        .sp_out(sp_out), .ptr_addr(ptr_addr), .ptr_we(ptr_we),
        .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seed_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory seen by the design
    logic [7:0] tb_mem [int];
    function automatic logic [7:0] tb_get(input logic [15:0] a);
        return tb_mem.exists(int'(a)) ? tb_mem[int'(a)] : seed_byte(a);
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) tb_mem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= tb_get(mem_addr);
        end
    end

    // behavioural reference model
    logic [7:0]  mm [int];
    logic [15:0] m_sp = '0, m_dat = '0, m_pop = '0;
    logic [1:0]  m_op = '0;
    int          m_cnt = 0;
    logic        m_done = 1'b0;

    function automatic logic [7:0] m_get(input logic [15:0] a);
        return mm.exists(int'(a)) ? mm[int'(a)] : seed_byte(a);
    endfunction

    always @(posedge clk) begin
        logic [15:0] t;
        logic [7:0]  lo, hi;
        if (rst) begin
            m_sp = '0; m_cnt = 0; m_done = 1'b0; m_pop = '0;
        end else begin
            m_done = 1'b0;
            if (m_cnt == 0) begin
                if (ptr_we && ptr_addr == 8'h5D) m_sp[7:0]  = ptr_wdata;
                if (ptr_we && ptr_addr == 8'h5E) m_sp[15:8] = ptr_wdata;
                if (cmd_valid) begin
                    m_op = cmd_op; m_dat = cmd_wdata;
                    m_cnt = cmd_op[1] ? 3 : 2;
                end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    case (m_op)
                        2'b00: begin mm[int'(m_sp)] = m_dat[7:0]; m_sp = m_sp - 16'd1; end
                        2'b01: begin m_sp = m_sp + 16'd1; m_pop = {8'h00, m_get(m_sp)}; end
                        2'b10: begin
                            mm[int'(m_sp)] = m_dat[15:8];
                            t = m_sp - 16'd1;
                            mm[int'(t)] = m_dat[7:0];
                            m_sp = m_sp - 16'd2;
                        end
                        default: begin
                            lo = m_get(m_sp + 16'd1);
                            hi = m_get(m_sp + 16'd2);
                            m_sp = m_sp + 16'd2;
                            m_pop = {hi, lo};
                        end
                    endcase
                end
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        logic        first, en_exp;
        logic [15:0] a_exp;
        logic [7:0]  rd_exp;
        if (!rst) begin
            first  = m_op[1] ? (m_cnt == 3) : (m_cnt == 2);
            en_exp = m_op[1] ? (m_cnt == 3 || m_cnt == 2) : (m_cnt == 2);
            rd_exp = (ptr_addr == 8'h5D) ? m_sp[7:0] : (ptr_addr == 8'h5E) ? m_sp[15:8] : 8'h00;
            chk(32'(busy), 32'(m_cnt != 0), "R8 busy");
            chk(32'(done), 32'(m_done), "R8 done");
            chk(32'(sp_out), 32'(m_sp), "R3/R4/R5/R6/R7 pointer");
            chk(32'(pop_data), 32'(m_pop), "R10 pop result");
            chk(32'(ptr_rdata), 32'(rd_exp), "R2 pointer readback");
            chk(32'(mem_en), 32'(en_exp), "R8 memory enable");
            if (en_exp) begin
                if (m_op[0]) a_exp = m_sp + (first ? 16'd1 : 16'd2);
                else         a_exp = first ? m_sp : m_sp - 16'd1;
                chk(32'(mem_addr), 32'(a_exp), "R3/R4/R5/R6/R7 memory address");
                chk(32'(mem_we), 32'(!m_op[0]), "R11 write enable");
                if (!m_op[0])
                    chk(32'(mem_wdata), 32'((m_op[1] && first) ? m_dat[15:8] : m_dat[7:0]),
                        "R3/R5 write data");
            end
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    // issues one command and returns at the negedge where done is due
    task automatic run_cmd(input logic [1:0] op, input logic [15:0] d, input bit imm);
        if (!imm) begin
            @(negedge clk);
            while (busy) @(negedge clk);
        end
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (op[1] ? 3 : 2) @(negedge clk);
        chk(32'(done), 32'd1, "R8 done due cycle");
    endtask

    task automatic ptr_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        ptr_addr = a; ptr_we = 1'b1; ptr_wdata = v;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(32'(sp_out), 32'h0, "R1 pointer reset");
        chk(32'(busy), 32'h0, "R1 busy reset");
        chk(32'(done), 32'h0, "R1 done reset");
        chk(32'(pop_data), 32'h0, "R1 result reset");
        rst = 1'b0;
        @(negedge clk);
        chk(32'(sp_out), 32'h0, "R1 pointer after release");

        // R2 pointer access
        ptr_write(8'h5D, 8'h10);
        ptr_write(8'h5E, 8'h02);
        chk(32'(sp_out), 32'h0210, "R2 pointer write");
        ptr_write(8'h5C, 8'hFF);
        ptr_write(8'h5F, 8'hFF);
        chk(32'(sp_out), 32'h0210, "R2 foreign write ignored");
        ptr_addr = 8'h40; #0.1;
        chk(32'(ptr_rdata), 32'h0, "R2 foreign read zero");
        ptr_addr = 8'h5E; #0.1;
        chk(32'(ptr_rdata), 32'h02, "R2 high readback");

        // R3 R4 R5 R6 R11 basic ordering
        run_cmd(2'b00, 16'h00A5, 0);
        chk(32'(sp_out), 32'h020F, "R3 byte push pointer");
        run_cmd(2'b10, 16'h1234, 0);
        chk(32'(sp_out), 32'h020D, "R5 address push pointer");
        run_cmd(2'b11, 16'h0000, 0);
        chk(32'(pop_data), 32'h1234, "R6 address pop value");
        run_cmd(2'b01, 16'h0000, 0);
        chk(32'(pop_data), 32'h00A5, "R4 byte pop value");
        chk(32'(sp_out), 32'h0210, "R4 pointer back");

        // R7 wrap
        ptr_write(8'h5D, 8'h00);
        ptr_write(8'h5E, 8'h00);
        run_cmd(2'b10, 16'hBEEF, 0);
        chk(32'(sp_out), 32'hFFFE, "R7 push wraps");
        run_cmd(2'b11, 16'h0000, 0);
        chk(32'(pop_data), 32'hBEEF, "R7 pop across wrap");
        chk(32'(sp_out), 32'h0000, "R7 pointer wraps up");
        ptr_write(8'h5D, 8'hFF);
        ptr_write(8'h5E, 8'hFF);
        run_cmd(2'b01, 16'h0000, 0);
        chk(32'(pop_data), 32'h00BE, "R7 byte pop at 0x0000");

        // R10 push keeps result; back-to-back in done cycle
        run_cmd(2'b00, 16'h0077, 1);
        chk(32'(pop_data), 32'h00BE, "R10 result held over push");

        // R9 commands and pointer writes during busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_wdata = 16'h0011;
        @(negedge clk);
        cmd_op = 2'b11; ptr_addr = 8'h5E; ptr_we = 1'b1; ptr_wdata = 8'h77;
        @(negedge clk);
        cmd_valid = 1'b0; ptr_we = 1'b0;
        @(negedge clk);
        chk(32'(done), 32'd1, "R9 done for first command");
        chk(32'(sp_out), 32'hFFFE, "R9 pointer unaffected by busy write");
        @(negedge clk);
        chk(32'(busy), 32'd0, "R9 busy command dropped");

        // randomised mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) ptr_write(8'h5D + 8'($urandom % 2), 8'($urandom));
            run_cmd(2'($urandom), 16'($urandom), (r == 1));
            if (r == 2) repeat (2) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule